// File: doc/BRIEF.md
# Preamble Run Detector

This block watches a stream of read-data pulses that have already been aligned to the recovered clock. It measures the spacing between successive pulses in clock periods (T) and compares it to the preamble period chosen by a 2-bit select. Once enough correctly spaced pulses have arrived in an unbroken run, it raises a detected flag. The flag can steer the frequency-to-phase lock hand-over of a read-channel sequencer.

Counting is allowed only while read mode is on and the zero-phase-start sequence has finished. The first pulse in a run only sets the timing reference. Every later pulse that lands exactly one period after its predecessor extends the run. An early pulse, a late pulse, or a missing pulse ends the run and starts a new one. The run length needed is 32 for the three shorter periods and 16 for the 4T period. The flag stays set until read mode ends.

Top module: `preamble_detector`

## Requirements
- R1: `pat_sel_i` gives the expected pulse spacing in clock cycles. Value 0 means 1 cycle, 1 means 2 cycles, 2 means 3 cycles and 3 means 4 cycles. For 1T, pulses are sampled high on consecutive rising edges. Pulses at any other spacing never assert the flag.
- R2: `det_o` rises straight after the rising edge that samples the 32nd matching interval when `pat_sel_i` is 0, 1 or 2. It rises after the 16th matching interval when `pat_sel_i` is 3. It does not rise one interval earlier.
- R3: No pulse is counted unless `rd_en_i` and `zps_done_i` are both high. A cycle with either input low discards the run in progress.
- R4: Once `det_o` is high, it stays high while `rd_en_i` stays high. This holds whatever happens on the pulses, on `zps_done_i` or on `pat_sel_i`.
- R5: `det_o` is low in every cycle in which `rd_en_i` is low, including during reset.
- R6: A pulse that arrives earlier or later than the selected spacing clears the run. That pulse becomes the new reference.
- R7: If no pulse has arrived by the selected spacing plus one cycle, the run is cleared. The next pulse is then taken as a fresh reference.
- R8: The first pulse after counting is enabled, or after a run is cleared, only sets the reference. It is not counted as a match, so a full run needs one more pulse than the required number of intervals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Recovered clock, one period is T |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_en_i | input | 1 | Read mode enable |
| zps_done_i | input | 1 | Zero-phase-start sequence complete |
| pat_sel_i | input | 2 | Preamble period select (spacing = value + 1 cycles) |
| pulse_i | input | 1 | Clock-aligned data pulse, one cycle per recorded bit |
| det_o | output | 1 | Latched preamble detected flag |

## Verification
The hardest cases are restarted runs. The count after an early pulse, a late pulse or a dropped zero-phase-start must begin again with the offending pulse taken as the reference. From the ports, such a restart looks almost the same as a counter that kept its old value. To separate the two, the stimulus first builds a partial run of 10 to 20 matching intervals. It then injects one pulse that is one cycle early, a gap that passes the timeout, or a one-cycle drop of the enable. After that it sends exactly the number of pulses that a correct restart needs. The flag is expected on the last of these pulses and not on any earlier one. A design that kept the old count would raise the flag early, and one that counted the reference would raise it one pulse early.

// File: rtl/pd_pkg.sv
package pd_pkg;
  localparam int unsigned SEL_W   = 2;
  localparam int unsigned NUM_PAT = 1 << SEL_W;
  // spacing counter must reach longest period + 1 (timeout point)
  localparam int unsigned GAP_W   = $clog2(NUM_PAT + 2);

  typedef enum logic [SEL_W-1:0] {
    PAT_1T = 2'd0,
    PAT_2T = 2'd1,
    PAT_3T = 2'd2,
    PAT_4T = 2'd3
  } pat_e;

  typedef logic [GAP_W-1:0] gap_t;

  function automatic gap_t period_of(input logic [SEL_W-1:0] sel);
    return gap_t'(sel) + gap_t'(1);
  endfunction
endpackage

// File: rtl/pd_gap_timer.sv
module pd_gap_timer
  import pd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic pulse_i,
  input  gap_t period_i,
  output logic hit_o,
  output logic miss_o
);
  logic have_ref_q;
  gap_t gap_q;
  logic on_time, off_time, timeout;

  assign on_time  = en_i & pulse_i & have_ref_q & (gap_q == period_i);
  assign off_time = en_i & pulse_i & have_ref_q & (gap_q != period_i);
  assign timeout  = en_i & ~pulse_i & have_ref_q & (gap_q == period_i + gap_t'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_ref_q <= 1'b0;
      gap_q      <= '0;
    end else if (!en_i) begin
      have_ref_q <= 1'b0;
      gap_q      <= '0;
    end else if (pulse_i) begin
      have_ref_q <= 1'b1;           // every pulse is the next reference
      gap_q      <= gap_t'(1);
    end else if (timeout) begin
      have_ref_q <= 1'b0;
      gap_q      <= '0;
    end else if (have_ref_q) begin
      gap_q      <= gap_q + gap_t'(1);
    end
  end

  assign hit_o  = on_time;
  assign miss_o = off_time | timeout;
endmodule

// File: rtl/pd_run_counter.sv
module pd_run_counter #(
  parameter int unsigned RUN_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             hit_i,
  input  logic             miss_i,
  input  logic [RUN_W-1:0] need_i,
  output logic [RUN_W-1:0] run_o,
  output logic             reach_o
);
  logic [RUN_W-1:0] run_q;
  logic [RUN_W:0]   nxt;

  assign nxt     = {1'b0, run_q} + (RUN_W+1)'(1);
  assign reach_o = hit_i & (nxt >= {1'b0, need_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           run_q <= '0;
    else if (!en_i || miss_i)              run_q <= '0;
    else if (hit_i && nxt <= {1'b0, need_i}) run_q <= nxt[RUN_W-1:0];
  end

  assign run_o = run_q;
endmodule

// File: rtl/pd_det_latch.sv
module pd_det_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_en_i,
  input  logic set_i,
  output logic det_q_o,
  output logic det_o
);
  logic det_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      det_q <= 1'b0;
    else if (!rd_en_i) det_q <= 1'b0;
    else if (set_i)   det_q <= 1'b1;
  end

  assign det_q_o = det_q;
  assign det_o   = det_q & rd_en_i;   // forced low without waiting for an edge
endmodule

// File: rtl/preamble_detector.sv
module preamble_detector
  import pd_pkg::*;
#(
  parameter int unsigned LONG_RUN  = 32,
  parameter int unsigned SHORT_RUN = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_en_i,
  input  logic             zps_done_i,
  input  logic [SEL_W-1:0] pat_sel_i,
  input  logic             pulse_i,
  output logic             det_o
);
  localparam int unsigned RUN_W = $clog2(LONG_RUN + 1);

  logic             cnt_en;
  gap_t             period;
  logic [RUN_W-1:0] need;
  logic             hit, miss, reach;
  logic [RUN_W-1:0] run_cnt;
  logic             det_q;

  assign cnt_en = rd_en_i & zps_done_i;
  assign period = period_of(pat_sel_i);
  assign need   = (pat_e'(pat_sel_i) == PAT_4T) ? RUN_W'(SHORT_RUN) : RUN_W'(LONG_RUN);

  pd_gap_timer u_gap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (cnt_en),
    .pulse_i  (pulse_i),
    .period_i (period),
    .hit_o    (hit),
    .miss_o   (miss)
  );

  pd_run_counter #(.RUN_W(RUN_W)) u_run (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (cnt_en),
    .hit_i   (hit),
    .miss_i  (miss),
    .need_i  (need),
    .run_o   (run_cnt),
    .reach_o (reach)
  );

  pd_det_latch u_det (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_en_i (rd_en_i),
    .set_i   (reach),
    .det_q_o (det_q),
    .det_o   (det_o)
  );
endmodule

// File: rtl/pd_checker.sv
module pd_checker #(
  parameter int unsigned LONG_RUN = 32,
  parameter int unsigned RUN_W    = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rd_en_i,
  input logic             zps_done_i,
  input logic             pulse_i,
  input logic             det_o,
  input logic             det_q,
  input logic [RUN_W-1:0] run_cnt
);
  // R2: run never exceeds longest required length
  a_r2_run_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_cnt <= RUN_W'(LONG_RUN));

  // R3: flag can only rise after an enabled cycle
  a_r3_rise_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(det_o) |-> ($past(rd_en_i) && $past(zps_done_i)));

  // R4: latched while read mode stays on
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_o |=> (det_o || !rd_en_i));

  // R5: stored flag cleared after a cycle with read mode off
  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !det_q);

  // R2: flag rises only on the edge that sampled a pulse
  a_r2_rise_on_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(det_q) |-> $past(pulse_i));
endmodule

bind preamble_detector pd_checker #(.LONG_RUN(LONG_RUN), .RUN_W(RUN_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_en_i    (rd_en_i),
  .zps_done_i (zps_done_i),
  .pulse_i    (pulse_i),
  .det_o      (det_o),
  .det_q      (det_q),
  .run_cnt    (run_cnt)
);

// File: tb/preamble_detector_tb_top.sv
module preamble_detector_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_en = 1'b0;
  logic       zps = 1'b0;
  logic [1:0] sel = 2'd0;
  logic       pulse = 1'b0;
  logic       det;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  item_t q[$];
  int    n_vec = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  logic  exp_det = 1'b0;

  always #4 clk = ~clk;

  preamble_detector dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .rd_en_i    (rd_en),
    .zps_done_i (zps),
    .pat_sel_i  (sel),
    .pulse_i    (pulse),
    .det_o      (det)
  );

  // monitor: compare one expected item per rising edge, 1 ns after it
  always @(posedge clk) begin
    item_t it;
    #1;
    if (q.size() > 0) begin
      it = q.pop_front();
      n_vec++;
      if (det !== it.exp) begin
        n_bad++;
        $display("FAIL %s: det_o=%0b expected %0b", it.tag, det, it.exp);
      end
    end
  end

  // driver: inputs applied at a falling edge, hold through the next rising edge
  task automatic cyc(input logic p, input logic e, input string tag);
    item_t x;
    pulse = p;
    x.exp = e;
    x.tag = tag;
    q.push_back(x);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) cyc(1'b0, exp_det, tag);
  endtask

  // pulse i (0 = reference) completes i matching intervals
  task automatic train(input int n, input int sp, input int lead, input int need, input string tag);
    for (int i = 0; i < n; i++) begin
      int gap;
      gap = (i == 0) ? lead : sp - 1;
      for (int k = 0; k < gap; k++) cyc(1'b0, exp_det, tag);
      if (i >= need) exp_det = 1'b1;
      cyc(1'b1, exp_det, tag);
    end
  endtask

  task automatic read_off(input string tag);
    rd_en = 1'b0;
    exp_det = 1'b0;
    idle(2, tag);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(1'b0, 1'b0, "R5 reset state");

    // R5: read mode off, pulses ignored
    zps = 1'b1; sel = 2'd0;
    train(40, 1, 0, 1000, "R5 read off");

    // R3: zps not done, nothing counted
    rd_en = 1'b1; zps = 1'b0;
    train(40, 1, 0, 1000, "R3 zps low");

    // R2/R8 1T: 33 pulses, flag on the 33rd
    zps = 1'b1;
    idle(2, "R3 enabled idle");
    train(33, 1, 0, 32, "R2/R8 1T run of 32");

    // R4: junk pulses and zps drop keep the flag
    train(10, 3, 1, 1000, "R4 hold under junk");
    zps = 1'b0;
    idle(3, "R4 zps drop keeps flag");
    zps = 1'b1;
    sel = 2'd3;
    idle(2, "R4 select change keeps flag");
    read_off("R5 flag cleared");

    // R2 4T: 17 pulses
    rd_en = 1'b1; sel = 2'd3;
    idle(2, "R2 idle");
    train(17, 4, 0, 16, "R2 4T run of 16");
    read_off("R5 clear");

    // R1: wrong spacing never detects
    rd_en = 1'b1; sel = 2'd0;
    train(40, 2, 0, 1000, "R1 2T spacing under 1T select");
    sel = 2'd1;
    train(40, 1, 2, 1000, "R1 1T spacing under 2T select");
    sel = 2'd2;
    train(40, 4, 2, 1000, "R1 4T spacing under 3T select");
    read_off("R5 clear");

    // R1/R2 3T correct spacing
    rd_en = 1'b1; sel = 2'd2;
    idle(2, "R1 idle");
    train(33, 3, 0, 32, "R1/R2 3T run of 32");
    read_off("R5 clear");

    // R6: early pulse restarts with itself as reference
    rd_en = 1'b1; sel = 2'd1;
    idle(2, "R6 idle");
    train(21, 2, 0, 1000, "R6 partial run");
    train(33, 2, 0, 32, "R6 early pulse restarts run");
    read_off("R5 clear");

    // R7: missing pulse restarts
    rd_en = 1'b1; sel = 2'd2;
    idle(2, "R7 idle");
    train(11, 3, 0, 1000, "R7 partial run");
    train(33, 3, 4, 32, "R7 missing pulse restarts run");
    read_off("R5 clear");

    // R6: late pulse on 4T
    rd_en = 1'b1; sel = 2'd3;
    idle(2, "R6 idle");
    train(10, 4, 0, 1000, "R6 partial 4T run");
    train(17, 4, 4, 16, "R6 late pulse restarts 4T run");
    read_off("R5 clear");

    // R3: zps drop mid-run discards progress
    rd_en = 1'b1; sel = 2'd0;
    train(20, 1, 0, 1000, "R3 partial run");
    zps = 1'b0;
    idle(1, "R3 zps drop");
    zps = 1'b1;
    train(33, 1, 0, 32, "R3 restart after zps drop");
    read_off("R5 clear");

    // R8: 16 pulses at 4T give only 15 intervals
    rd_en = 1'b1; sel = 2'd3;
    idle(2, "R8 idle");
    train(16, 4, 0, 1000, "R8 reference not counted");
    idle(3, "R8 before final pulse");
    exp_det = 1'b1;
    cyc(1'b1, exp_det, "R8 sixteenth interval");
    idle(2, "R4 hold");
    read_off("R5 final clear");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule